// File: doc/BRIEF.md
# Register File with Return-Address Stack

This block is the integer register file of a small processor core. It holds 32 registers of 32 bits, serves two combinational read ports and one write port, and takes a strobe that marks the retirement of the current instruction. Register 0 is a constant zero. Register 1 is not a storage location: it is the visible top of a hardware last-in/first-out stack of return addresses.

An enabled read of register 1 returns the current stack top and marks a pop for the instruction. A write to register 1 marks a push of the written value. Neither takes effect until the instruction retires. At retirement the pop, if any, is applied first and then the push. Between retirements, register 1 keeps its value from before the instruction. An empty stack makes register 1 read as zero. A push that finds the stack full is dropped and raises a sticky overflow flag. A pop that finds the stack empty does nothing and raises a sticky underflow flag.

Top module: `gpr_retstack_file`

## Requirements
- R1: Address 0 always reads zero on both read ports, and a write to address 0 has no effect.
- R2: A write with `wr_en` high to an address from 2 to 31 is stored at the clock edge and reads back on both read ports from the next cycle on.
- R3: A write to address 1 leaves the value read at address 1 unchanged until retirement. After the retiring edge, address 1 reads the pushed value.
- R4: A read of address 1 with its port enable high returns the stack top from before the instruction and marks a pop. After retirement, address 1 reads the entry below, in last-in/first-out order. A read with the enable low marks nothing.
- R5: When one instruction both pops and pushes, the pop is applied first, so the top entry is replaced and the depth is unchanged. This holds on a full stack without raising overflow.
- R6: An empty stack reads as zero at address 1. A pop on an empty stack leaves it empty and sets the sticky underflow flag `stk_underflow`.
- R7: A push with no pop that finds the stack holding `STACK_DEPTH` entries is discarded, leaves the top unchanged, and sets the sticky overflow flag `stk_overflow`.
- R8: Marked pops and pushes are cleared at every retirement, so a later retirement with no access to address 1 changes nothing.
- R9: Accesses to address 1 made in the same cycle as `retire` belong to that retirement.
- R10: After reset all registers read zero, the stack is empty, and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_en | input | 1 | Port A read is architectural (address 1 then marks a pop) |
| rd_a_addr | input | 5 | Port A register address |
| rd_b_en | input | 1 | Port B read is architectural |
| rd_b_addr | input | 5 | Port B register address |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write register address |
| wr_data | input | 32 | Write data |
| retire | input | 1 | Current instruction retires at this edge |
| rd_a_data | output | 32 | Port A read data (combinational) |
| rd_b_data | output | 32 | Port B read data (combinational) |
| stk_overflow | output | 1 | Sticky flag: a push was dropped on a full stack |
| stk_underflow | output | 1 | Sticky flag: a pop hit an empty stack |

## Verification
Read data is combinational, so it is due in the same cycle as its address. A flat register write shows up one edge later. Any push or pop, together with its flag, shows up only after the edge where `retire` is high. The bench therefore drives each instruction on the falling edge, samples read data 1 ns later in that same cycle, and checks stack effects in the cycle after the retiring edge. It sweeps every address with computed values and fills, overfills and drains the stack against a model held in the bench.

// File: rtl/gpr_retstack_pkg.sv
// Package: shared constants for the register file with return-address stack.
// Assumes a 32-entry architectural register space addressed by 5 bits.
package gpr_retstack_pkg;
    localparam int unsigned GPR_COUNT  = 32;
    localparam int unsigned GPR_AW     = $clog2(GPR_COUNT);
    localparam int unsigned ZERO_IDX   = 0;
    localparam int unsigned LINK_IDX   = 1;
    typedef logic [GPR_AW-1:0] gpr_addr_t;
endpackage

// File: rtl/gpr_flat_bank.sv
// Module: flat storage for every register except the zero and link slots.
// Assumes the link slot is served elsewhere; slots 0 and 1 read as zero here.
module gpr_flat_bank
    import gpr_retstack_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gpr_addr_t         rd_a_addr,
    input  gpr_addr_t         rd_b_addr,
    input  logic              wr_en,
    input  gpr_addr_t         wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data
);
    logic [DATA_W-1:0] slot [GPR_COUNT];

    for (genvar g = 0; g < GPR_COUNT; g++) begin : g_slot
        if (g == ZERO_IDX || g == LINK_IDX) begin : g_const
            // Slot without storage: constant zero.
            assign slot[g] = '0;
        end else begin : g_flop
            // Slot register: cleared at reset, loaded on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot[g] <= '0;
                else if (wr_en && wr_addr == gpr_addr_t'(g))
                    slot[g] <= wr_data;
            end
        end
    end

    // Combinational read of both ports.
    always_comb begin
        rd_a_data = slot[rd_a_addr];
        rd_b_data = slot[rd_b_addr];
    end

    // R2: a write to a plain slot is visible on port A one cycle later
    assert_flat_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > gpr_addr_t'(LINK_IDX) && rd_a_addr == wr_addr)
        |=> ($stable(rd_a_addr) -> rd_a_data == $past(wr_data)));
endmodule

// File: rtl/retstack_lifo.sv
// Module: last-in/first-out stack of return addresses with sticky status.
// Within one update the pop is applied before the push. An empty stack shows
// a zero top. Assumes STACK_DEPTH >= 2.
module retstack_lifo #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_val_i,
    output logic [DATA_W-1:0] top_o,
    output logic              ovf_o,
    output logic              unf_o
);
    localparam int unsigned CW = $clog2(STACK_DEPTH + 1);
    localparam int unsigned AW = $clog2(STACK_DEPTH);

    logic [DATA_W-1:0] mem [STACK_DEPTH];
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     cnt_mid;
    logic              room;

    // Depth after the pop and whether the push then fits.
    always_comb begin
        cnt_mid = (pop_i && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
        room    = (cnt_mid != CW'(STACK_DEPTH));
    end

    // Depth counter and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            if (pop_i && cnt_q == '0)
                unf_o <= 1'b1;
            if (push_i && !room)
                ovf_o <= 1'b1;
            cnt_q <= (push_i && room) ? cnt_mid + 1'b1 : cnt_mid;
        end
    end

    // Entry storage: a push lands just above the depth left by the pop.
    always_ff @(posedge clk) begin
        if (push_i && room)
            mem[cnt_mid[AW-1:0]] <= push_val_i;
    end

    // Visible top: zero when empty.
    always_comb begin
        top_o = (cnt_q == '0) ? '0 : mem[AW'(cnt_q - 1'b1)];
    end

    // R7: the depth never exceeds its bound
    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(STACK_DEPTH));
    // R7: a lone push on a full stack is dropped and flagged
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && cnt_q == CW'(STACK_DEPTH)) |=> ($stable(cnt_q) && ovf_o));
    // R7: overflow is sticky
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    // R6: a lone pop on an empty stack keeps it empty and flags underflow
    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && cnt_q == '0) |=> (cnt_q == '0 && unf_o));
    // R6: underflow is sticky
    assert_unf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);
    // R5: a pop and a push together on a non-empty stack keep the depth
    assert_swap_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && push_i && cnt_q != '0) |=> $stable(cnt_q));
endmodule

// File: rtl/gpr_retstack_file.sv
// Module: register file with a constant-zero register and a link register
// backed by a return-address stack. Link reads and writes are collected during
// an instruction and applied together when retire is high, pop before push.
// Assumes at most one write per cycle and that retire marks the instruction's
// last cycle.
module gpr_retstack_file
    import gpr_retstack_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_a_en,
    input  logic [4:0]        rd_a_addr,
    input  logic              rd_b_en,
    input  logic [4:0]        rd_b_addr,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              retire,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              stk_overflow,
    output logic              stk_underflow
);
    localparam gpr_addr_t LINK = gpr_addr_t'(LINK_IDX);

    logic [DATA_W-1:0] bank_a, bank_b, link_top;
    logic              pend_pop_q, pend_push_q;
    logic [DATA_W-1:0] pend_val_q;
    logic              cur_pop, cur_push;
    logic              eff_pop, eff_push;
    logic [DATA_W-1:0] eff_val;

    gpr_flat_bank #(.DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_addr (rd_a_addr),
        .rd_b_addr (rd_b_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_a_data (bank_a),
        .rd_b_data (bank_b)
    );

    // Merge this cycle's link accesses with those already marked.
    always_comb begin
        cur_pop  = (rd_a_en && rd_a_addr == LINK) || (rd_b_en && rd_b_addr == LINK);
        cur_push = wr_en && wr_addr == LINK;
        eff_pop  = pend_pop_q || cur_pop;
        eff_push = pend_push_q || cur_push;
        eff_val  = cur_push ? wr_data : pend_val_q;
    end

    // Marked pop/push: accumulate until retire, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n || retire) begin
            pend_pop_q  <= 1'b0;
            pend_push_q <= 1'b0;
            pend_val_q  <= '0;
        end else begin
            pend_pop_q  <= eff_pop;
            pend_push_q <= eff_push;
            pend_val_q  <= eff_val;
        end
    end

    retstack_lifo #(.DATA_W(DATA_W), .STACK_DEPTH(STACK_DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop_i      (retire && eff_pop),
        .push_i     (retire && eff_push),
        .push_val_i (eff_val),
        .top_o      (link_top),
        .ovf_o      (stk_overflow),
        .unf_o      (stk_underflow)
    );

    // Read ports: link slot comes from the stack top.
    always_comb begin
        rd_a_data = (rd_a_addr == LINK) ? link_top : bank_a;
        rd_b_data = (rd_b_addr == LINK) ? link_top : bank_b;
    end

    // R1: address 0 reads zero on both ports
    assert_zero_reg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0 -> rd_a_data == '0) && (rd_b_addr == '0 -> rd_b_data == '0));
    // R8: marks are cleared after each retirement
    assert_marks_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (!pend_pop_q && !pend_push_q));
    // R3: without a retirement the link value does not move
    assert_link_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> $stable(link_top));
endmodule

// File: tb/gpr_retstack_file_bench.sv
module gpr_retstack_file_bench;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_a_en, rd_b_en, wr_en, retire;
    logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [31:0] wr_data, rd_a_data, rd_b_data;
    logic        stk_overflow, stk_underflow;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] a_q, b_q;
    logic [31:0] model [DEPTH];
    int          mdep;

    always #2 clk = ~clk;

    gpr_retstack_file #(.DATA_W(32), .STACK_DEPTH(DEPTH)) u_gpr_retstack_file (
        .clk(clk), .rst_n(rst_n),
        .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr),
        .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .retire(retire),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .stk_overflow(stk_overflow), .stk_underflow(stk_underflow)
    );

    function automatic logic [31:0] pat(input int i);
        return 32'h1357_9BDF + 32'(i) * 32'h0101_0305;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, driven at the falling edge; reads sampled 1 ns later.
    task automatic cyc(input logic ae, input logic [4:0] aa, input logic be, input logic [4:0] ba,
                       input logic we, input logic [4:0] wa, input logic [31:0] wd, input logic ret);
        @(negedge clk);
        rd_a_en = ae; rd_a_addr = aa; rd_b_en = be; rd_b_addr = ba;
        wr_en = we; wr_addr = wa; wr_data = wd; retire = ret;
        #1;
        a_q = rd_a_data; b_q = rd_b_data;
    endtask

    task automatic idle();
        cyc(1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0);
    endtask

    task automatic peek_link(output logic [31:0] v);
        cyc(1'b0, 5'd1, 1'b0, 5'd1, 1'b0, 5'd0, 32'h0, 1'b0);
        v = a_q;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        idle();
        rst_n = 1'b1;
        mdep = 0;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] x;
        rst_n = 1'b0;
        rd_a_en = 0; rd_b_en = 0; wr_en = 0; retire = 0;
        rd_a_addr = 0; rd_b_addr = 0; wr_addr = 0; wr_data = 0;
        do_reset();

        // R10: reset state
        for (int i = 0; i < 32; i++) begin
            cyc(1'b0, 5'(i), 1'b0, 5'(31 - i), 1'b0, 5'd0, 32'h0, 1'b0);
            chk("R10 reset read A", a_q, 32'h0);
            chk("R10 reset read B", b_q, 32'h0);
        end
        chk("R10 overflow low", {31'h0, stk_overflow}, 32'h0);
        chk("R10 underflow low", {31'h0, stk_underflow}, 32'h0);

        // R2 / R1: sweep writes over every address except the link slot
        for (int i = 0; i < 32; i++)
            if (i != 1) cyc(1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'(i), pat(i), 1'b0);
        idle();
        for (int i = 0; i < 32; i++) begin
            if (i == 1) continue;
            cyc(1'b0, 5'(i), 1'b0, 5'(i), 1'b0, 5'd0, 32'h0, 1'b0);
            chk(i == 0 ? "R1 zero reg A" : "R2 flat read A", a_q, i == 0 ? 32'h0 : pat(i));
            chk(i == 0 ? "R1 zero reg B" : "R2 flat read B", b_q, i == 0 ? 32'h0 : pat(i));
        end
        // R2: a write is visible the cycle after its edge
        cyc(1'b0, 5'd7, 1'b0, 5'd0, 1'b1, 5'd7, 32'hCAFE_0007, 1'b0);
        chk("R2 same-cycle old value", a_q, pat(7));
        idle();
        cyc(1'b0, 5'd7, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0);
        chk("R2 next-cycle new value", a_q, 32'hCAFE_0007);

        // R3: link write held until retire
        cyc(1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd1, 32'hA000_0001, 1'b0);
        peek_link(v);
        chk("R3 link unchanged before retire", v, 32'h0);
        cyc(1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b1);
        peek_link(v);
        chk("R3 link after retire", v, 32'hA000_0001);
        // R9: access in the retire cycle counts
        cyc(1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd1, 32'hA000_0002, 1'b1);
        peek_link(v);
        chk("R9 push in retire cycle", v, 32'hA000_0002);
        // R4: enabled read returns pre-instruction top, pops at retire
        cyc(1'b0, 5'd0, 1'b1, 5'd1, 1'b0, 5'd0, 32'h0, 1'b0);
        chk("R4 read returns top", b_q, 32'hA000_0002);
        peek_link(v);
        chk("R4 no pop before retire", v, 32'hA000_0002);
        cyc(1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b1);
        peek_link(v);
        chk("R4 pop reveals lower entry", v, 32'hA000_0001);
        // R5: pop and push in one instruction replace the top
        cyc(1'b1, 5'd1, 1'b0, 5'd0, 1'b1, 5'd1, 32'hA000_0003, 1'b1);
        chk("R5 read sees old top", a_q, 32'hA000_0001);
        peek_link(v);
        chk("R5 top replaced", v, 32'hA000_0003);
        cyc(1'b1, 5'd1, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b1);
        peek_link(v);
        chk("R5 depth unchanged, now empty", v, 32'h0);
        chk("R6 no underflow yet", {31'h0, stk_underflow}, 32'h0);
        // R8: a bare retirement changes nothing
        cyc(1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b1);
        peek_link(v);
        chk("R8 bare retire keeps link", v, 32'h0);
        chk("R8 bare retire no underflow", {31'h0, stk_underflow}, 32'h0);
        // R4: a read with enable low does not pop
        cyc(1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd1, 32'hB000_0000, 1'b1);
        cyc(1'b0, 5'd1, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b1);
        peek_link(v);
        chk("R4 disabled read no pop", v, 32'hB000_0000);
        cyc(1'b1, 5'd1, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b1);
        // R6: pop on empty
        cyc(1'b1, 5'd1, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b1);
        peek_link(v);
        chk("R6 empty reads zero", v, 32'h0);
        chk("R6 underflow set", {31'h0, stk_underflow}, 32'h1);
        idle();
        chk("R6 underflow sticky", {31'h0, stk_underflow}, 32'h1);
        chk("R7 no overflow", {31'h0, stk_overflow}, 32'h0);

        // Fill, swap at full, overfill, drain
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            x = 32'hC000_0000 + 32'(i) * 32'h11;
            cyc(1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd1, x, 1'b1);
            model[mdep] = x; mdep++;
            peek_link(v);
            chk("R3 push sequence top", v, x);
        end
        chk("R7 full without overflow", {31'h0, stk_overflow}, 32'h0);
        cyc(1'b1, 5'd1, 1'b0, 5'd0, 1'b1, 5'd1, 32'hD00D_0001, 1'b1);
        model[mdep-1] = 32'hD00D_0001;
        peek_link(v);
        chk("R5 swap at full top", v, 32'hD00D_0001);
        chk("R5 swap at full no overflow", {31'h0, stk_overflow}, 32'h0);
        cyc(1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd1, 32'hDEAD_BEEF, 1'b1);
        peek_link(v);
        chk("R7 dropped push keeps top", v, 32'hD00D_0001);
        chk("R7 overflow set", {31'h0, stk_overflow}, 32'h1);
        while (mdep > 0) begin
            cyc(1'b0, 5'd0, 1'b1, 5'd1, 1'b0, 5'd0, 32'h0, 1'b1);
            chk("R4 drain order", b_q, model[mdep-1]);
            mdep--;
        end
        peek_link(v);
        chk("R6 drained reads zero", v, 32'h0);
        chk("R6 drain no underflow", {31'h0, stk_underflow}, 32'h0);
        chk("R7 overflow sticky", {31'h0, stk_overflow}, 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule